// File: doc/BRIEF.md
# Tapped Binary Ripple-Style Frequency Divider

This block divides an oscillator clock by successive powers of two through a chain of fourteen halving stages. Each stage runs at half the rate of the one before it, so stage k changes state at the input rate divided by 2^k. Only a chosen subset of the stages is brought out on the tap vector; the rest stay internal and read as zero. The stages are held in one synchronous register that advances on the falling edge of the oscillator clock. Every tap therefore changes together, not with the staggered timing of a true ripple chain.

An active-high reset clears every stage at once, without waiting for a clock edge. While reset is high the block also drops an oscillator-run output, so that an external oscillator can be stopped for standby. A decode strobe is high only while the clock is high and reset is low. That is the phase in which the count is stable, so logic that decodes several taps together can be gated with the strobe to avoid spikes. After reset falls, the clock source must allow a recovery interval before the first falling edge that is expected to count. This block does not enforce that interval.

There is no data stream, so the block has no valid/ready handshake. All pins are plain control or status levels.

Top module: `tapped_divider`

## Requirements
- R1: The divider has STAGES halving stages, 14 by default. Tap bit k-1 carries stage k, and stage k changes state once every 2^(k-1) falling edges, which is a full period of 2^k input cycles.
- R2: Each falling edge of `osc_clk` with reset low advances the count by one. The first falling edge after reset is released moves the count from 0 to 1. After 2^STAGES edges the count wraps back to 0.
- R3: While `rst` is high, all stages and all taps read zero. Reset takes effect at once, not at a clock edge, and clock edges during reset have no effect.
- R4: `osc_run` is low while `rst` is high and high while `rst` is low.
- R5: A tap bit is driven only where TAP_MASK has a one. The default mask exposes stages 4 to 10 and 12 to 14 (bits 3 to 9 and 11 to 13). Bits 0, 1, 2 and 10 always read zero.
- R6: `dec_strobe` is high exactly while `osc_clk` is high and `rst` is low, so it is low for the whole clock-low phase in which the count changes.
- R7: After reset is released, stage 14 (tap bit 13) first goes high on the 8192nd falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; the count advances on its falling edge |
| rst | input | 1 | Active-high asynchronous clear; also stops the oscillator |
| osc_run | output | 1 | High when the external oscillator may run |
| dec_strobe | output | 1 | High in the stable clock-high phase; qualifies tap decodes |
| taps | output | STAGES | Stage outputs; bit k-1 is stage k, and bits outside TAP_MASK read zero |

## Verification
The bench builds the block with its default values: fourteen stages and the mask that hides stages 1, 2, 3 and 11. With these values the full wrap after 16384 edges and the first rise of the top stage after 8192 edges can both be reached in a short run. The hidden stage 11 can be probed at count 1024, where the count is non-zero but every visible tap must read zero. A reset applied in the middle of a count, with the clock still toggling, shows the clear, the oscillator gating and the strobe suppression all at the same time.

// File: rtl/tdiv_pkg.sv
package tdiv_pkg;
  localparam int unsigned DEF_STAGES = 14;
  // stages 4..10 and 12..14 exposed (bit k-1 = stage k)
  localparam logic [DEF_STAGES-1:0] DEF_TAP_MASK = 14'h3BF8;
endpackage

// File: rtl/tdiv_counter.sv
module tdiv_counter #(
  parameter int unsigned STAGES = tdiv_pkg::DEF_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  output logic [STAGES-1:0] cnt
);
  localparam logic [STAGES-1:0] ONE = STAGES'(1);

  logic [STAGES-1:0] cnt_q;

  always_ff @(negedge clk or posedge rst) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + ONE;
  end

  assign cnt = cnt_q;

  // R2: each falling edge out of reset adds exactly one (wrapping)
  a_r2_step_by_one: assert property (@(negedge clk) disable iff (rst)
    1'b1 |=> cnt_q == $past(cnt_q) + ONE);

  // R3: held at zero whenever reset is sampled high
  a_r3_reset_clear: assert property (@(posedge clk)
    rst |-> cnt_q == '0);
endmodule

// File: rtl/tdiv_tap_select.sv
module tdiv_tap_select #(
  parameter int unsigned STAGES = tdiv_pkg::DEF_STAGES,
  parameter logic [STAGES-1:0] TAP_MASK = tdiv_pkg::DEF_TAP_MASK
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAGES-1:0] cnt,
  output logic [STAGES-1:0] taps
);
  for (genvar k = 0; k < STAGES; k++) begin : g_tap
    if (TAP_MASK[k]) begin : g_on
      assign taps[k] = cnt[k];
    end else begin : g_off
      assign taps[k] = 1'b0;
    end
  end

  // R5: nothing outside the mask is ever driven high
  a_r5_hidden_low: assert property (@(posedge clk) disable iff (rst)
    (taps & ~TAP_MASK) == '0);
endmodule

// File: rtl/tdiv_strobe.sv
module tdiv_strobe (
  input  logic clk,
  input  logic rst,
  output logic osc_run,
  output logic dec_strobe
);
  assign osc_run    = ~rst;
  assign dec_strobe = clk & ~rst;

  // R6: strobe is low in the phase just before a rising edge
  a_r6_strobe_low_phase: assert property (@(posedge clk) disable iff (rst)
    !dec_strobe);
endmodule

// File: rtl/tapped_divider.sv
module tapped_divider #(
  parameter int unsigned STAGES = tdiv_pkg::DEF_STAGES,
  parameter logic [STAGES-1:0] TAP_MASK = tdiv_pkg::DEF_TAP_MASK
) (
  input  logic              osc_clk,
  input  logic              rst,
  output logic              osc_run,
  output logic              dec_strobe,
  output logic [STAGES-1:0] taps
);
  logic [STAGES-1:0] cnt;

  tdiv_counter #(.STAGES(STAGES)) u_counter (
    .clk (osc_clk),
    .rst (rst),
    .cnt (cnt)
  );

  tdiv_tap_select #(.STAGES(STAGES), .TAP_MASK(TAP_MASK)) u_taps (
    .clk  (osc_clk),
    .rst  (rst),
    .cnt  (cnt),
    .taps (taps)
  );

  tdiv_strobe u_strobe (
    .clk        (osc_clk),
    .rst        (rst),
    .osc_run    (osc_run),
    .dec_strobe (dec_strobe)
  );

  // R4: oscillator stays gated off while reset is sampled high
  a_r4_osc_gated: assert property (@(posedge osc_clk)
    rst |-> !osc_run && taps == '0);
endmodule

// File: tb/tapped_divider_bench.sv
module tapped_divider_bench;
  localparam int unsigned W = 14;
  localparam int unsigned NV = 8;
  localparam int unsigned VEC_EDGES [NV] = '{1, 8, 15, 1024, 2048, 8192, 16383, 16384};
  localparam logic [W-1:0] VEC_TAPS [NV] =
    '{14'h0000, 14'h0008, 14'h0008, 14'h0000, 14'h0800, 14'h2000, 14'h3BF8, 14'h0000};

  logic osc_clk = 1'b0;
  logic rst = 1'b0;
  logic osc_run, dec_strobe;
  logic [W-1:0] taps;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 osc_clk = ~osc_clk;

  tapped_divider u_tapped_divider (
    .osc_clk    (osc_clk),
    .rst        (rst),
    .osc_run    (osc_run),
    .dec_strobe (dec_strobe),
    .taps       (taps)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic falls(input int unsigned n);
    repeat (n) @(negedge osc_clk);
    #2;
  endtask

  initial begin
    int unsigned done_edges;
    #1 rst = 1'b1;
    #10;
    check("R3 reset taps", 32'(taps), 0);
    check("R4 osc gated in reset", 32'(osc_run), 0);
    @(posedge osc_clk); #1;
    check("R6 strobe off in reset", 32'(dec_strobe), 0);
    rst = 1'b0;
    #1 check("R4 osc runs", 32'(osc_run), 1);
    check("R6 strobe high phase", 32'(dec_strobe), 1);

    // table walk: absolute edge counts since release
    done_edges = 0;
    for (int i = 0; i < int'(NV); i++) begin
      falls(VEC_EDGES[i] - done_edges);
      done_edges = VEC_EDGES[i];
      check($sformatf("R1/R5 taps after %0d edges", VEC_EDGES[i]), 32'(taps), 32'(VEC_TAPS[i]));
      check("R6 strobe low phase", 32'(dec_strobe), 0);
    end
    // wrap seen in last entry (R2); now 100 more edges
    falls(100);
    check("R2 count 100 after wrap", 32'(taps), 32'h60);
    @(posedge osc_clk); #2;
    check("R6 taps stable in strobe phase", 32'(taps), 32'h60);

    // reset mid-count, mid-phase
    rst = 1'b1;
    #1;
    check("R3 async clear", 32'(taps), 0);
    check("R4 osc gated", 32'(osc_run), 0);
    check("R6 strobe gated", 32'(dec_strobe), 0);
    falls(5);
    check("R3 edges ignored in reset", 32'(taps), 0);
    @(posedge osc_clk); #1;
    rst = 1'b0;
    falls(1);
    check("R2 first edge gives 1", 32'(taps), 0);
    falls(7);
    check("R2 count 8", 32'(taps), 32'h8);
    falls(8183);
    check("R7 top stage low at 8191", 32'(taps), 32'h1BF8);
    falls(1);
    check("R7 top stage rises at 8192", 32'(taps), 32'h2000);
    done = 1'b1;
  end

  initial begin
    int unsigned cyc = 0;
    while (!done && cyc < 60000) begin
      @(posedge osc_clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule